// File: doc/BRIEF.md
# Bus Target Claim Decoder

This block sits on the target side of a memory controller that is attached to a parallel, PCI-style shared bus. For every transaction an initiator starts, it looks at the command code, the address and a small bank of attribute registers, and decides whether the controller claims the cycle. A claimed cycle is steered either to main memory or to the internal configuration space. A cycle the block leaves unclaimed gets no response, and the initiator then master-aborts.

Main memory is everything below a programmable top-of-memory value. There is one exception: the legacy compatibility region from 0xC0000 to 0xFFFFF. It is split into sixteen 16 KB windows, and each window has its own read-enable and write-enable bit. Inside that region, a read is claimed only when the window's read enable is set, and a write only when its write enable is set. The top-of-memory value has no effect there.

After claiming a memory burst, the block counts the burst address up one 32-bit word per completed data phase. It raises a disconnect request on the last word of every 4 KB page, so that a burst never runs into a neighbouring page that might belong to another target. Bus phase sequencing, parity and the data path are handled elsewhere.

Top module: `tgt_claim_dec`

## Requirements
- R1: After reset, claim, route_cfg and disconnect are low. All window enables are clear and top-of-memory is zero, so no memory command is claimed until software loads them.
- R2: Memory read commands (codes 0x6, 0xC, 0xE) and memory write commands (codes 0x7, 0xF) whose address is below top-of-memory and outside 0xC0000–0xFFFFF are claimed with route_cfg low. Claim is high in the cycle after the clock edge that samples addr_valid.
- R3: A memory command whose address is at or above top-of-memory and outside the compatibility region is not claimed.
- R4: A memory write to address A in 0xC0000–0xFFFFF uses window index A[17:14]. It is claimed exactly when that window's write enable is set, whatever the top-of-memory value.
- R5: A memory read to address A in 0xC0000–0xFFFFF uses window index A[17:14]. It is claimed exactly when that window's read enable is set, whatever the top-of-memory value.
- R6: The interrupt-acknowledge (0x0), special-cycle (0x1), I/O read (0x2), I/O write (0x3), dual-address (0xD) and reserved (0x4, 0x5, 0x8, 0x9) codes are never claimed.
- R7: Configuration read (0xA) and configuration write (0xB) are claimed with route_cfg high exactly when cfg_sel is high in the address phase. A configuration cycle never raises disconnect.
- R8: Claim stays high until a clock edge that samples burst_end, and is low after it. An addr_valid on the same edge takes priority and starts a new decision.
- R9: In a claimed memory burst, the word address starts at the address-phase address and advances by 4 at each edge that samples data_done. disconnect is high exactly while the current address has bits [11:2] all ones.
- R10: A window-enable or top-of-memory load takes effect for address phases sampled after the loading edge. An address phase sampled on the same edge still uses the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_valid | input | 1 | Address phase strobe |
| cmd | input | 4 | Bus command code |
| addr | input | 32 | Address of the address phase |
| cfg_sel | input | 1 | Configuration cycle selects this device |
| data_done | input | 1 | A data phase completed this cycle |
| burst_end | input | 1 | Transaction finishes this cycle |
| attr_we | input | 1 | Load strobe for one window's enables |
| attr_idx | input | 4 | Window index to load |
| attr_rd | input | 1 | Read enable value to load |
| attr_wr | input | 1 | Write enable value to load |
| tom_we | input | 1 | Load strobe for top-of-memory |
| tom_val | input | 32 | Top-of-memory value (exclusive bound) |
| claim | output | 1 | Target claims the current transaction |
| route_cfg | output | 1 | Claimed transaction goes to configuration space |
| disconnect | output | 1 | Target requests a disconnect after this data phase |

## Verification
A window enable stored in the wrong slot, or a stale top-of-memory value, shows up at the first address phase that touches that window or bound: the decision is one clock late and claim takes the wrong value. A burst counter that is off by one word moves disconnect one data phase early or late, and this is seen at the first page end of the burst. A route or active flag that is not cleared leaves claim or route_cfg high one cycle after burst_end. The reference model compares all three outputs on every clock, so each of these faults is caught in the cycle where it first reaches a port.

// File: rtl/tcd_pkg.sv
`timescale 1ns/1ps
package tcd_pkg;

    typedef enum logic [3:0] {
        CMD_INTACK  = 4'h0,
        CMD_SPECIAL = 4'h1,
        CMD_IORD    = 4'h2,
        CMD_IOWR    = 4'h3,
        CMD_MEMRD   = 4'h6,
        CMD_MEMWR   = 4'h7,
        CMD_CFGRD   = 4'hA,
        CMD_CFGWR   = 4'hB,
        CMD_MEMRDM  = 4'hC,
        CMD_DUALADR = 4'hD,
        CMD_MEMRDL  = 4'hE,
        CMD_MEMWRI  = 4'hF
    } bus_cmd_e;

    typedef enum logic [1:0] {
        ACC_NONE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2,
        ACC_CFG   = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic hit;
        logic to_cfg;
    } claim_t;

endpackage

// File: rtl/tcd_regs.sv
`timescale 1ns/1ps
module tcd_regs #(
    parameter int ADDR_W  = 32,
    parameter int WIN_CNT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       attr_we,
    input  logic [$clog2(WIN_CNT)-1:0] attr_idx,
    input  logic                       attr_rd,
    input  logic                       attr_wr,
    input  logic                       tom_we,
    input  logic [ADDR_W-1:0]          tom_val,
    output logic [WIN_CNT-1:0]         rd_en,
    output logic [WIN_CNT-1:0]         wr_en,
    output logic [ADDR_W-1:0]          tom
);
    localparam int IDX_W = $clog2(WIN_CNT);

    typedef struct packed {
        logic [WIN_CNT-1:0] rd;
        logic [WIN_CNT-1:0] wr;
        logic [ADDR_W-1:0]  tom;
    } regs_t;

    regs_t regs_d, regs_q;
    logic [WIN_CNT-1:0] slot_sel;

    for (genvar w = 0; w < WIN_CNT; w++) begin : g_slot
        assign slot_sel[w] = attr_we && (attr_idx == IDX_W'(w));
    end

    always_comb begin
        regs_d = regs_q;
        for (int w = 0; w < WIN_CNT; w++) begin
            if (slot_sel[w]) begin
                regs_d.rd[w] = attr_rd;
                regs_d.wr[w] = attr_wr;
            end
        end
        if (tom_we) begin
            regs_d.tom = tom_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_en = regs_q.rd;
    assign wr_en = regs_q.wr;
    assign tom   = regs_q.tom;

endmodule

// File: rtl/tcd_decode.sv
`timescale 1ns/1ps
module tcd_decode
    import tcd_pkg::*;
#(
    parameter int              ADDR_W      = 32,
    parameter int              WIN_CNT     = 16,
    parameter int              WIN_SHIFT   = 14,
    parameter logic [ADDR_W-1:0] COMPAT_BASE = 32'h000C_0000
) (
    input  logic [3:0]         cmd,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               cfg_sel,
    input  logic [WIN_CNT-1:0] rd_en,
    input  logic [WIN_CNT-1:0] wr_en,
    input  logic [ADDR_W-1:0]  tom,
    output claim_t             decision
);
    localparam int IDX_W      = $clog2(WIN_CNT);
    localparam int REGION_LSB = WIN_SHIFT + IDX_W;
    localparam int TAG_W      = ADDR_W - REGION_LSB;
    localparam logic [TAG_W-1:0] REGION_TAG = COMPAT_BASE[ADDR_W-1:REGION_LSB];

    acc_kind_e        kind;
    logic             in_compat;
    logic [IDX_W-1:0] win;
    logic             below_tom;

    always_comb begin
        case (cmd)
            CMD_MEMRD, CMD_MEMRDM, CMD_MEMRDL: kind = ACC_READ;
            CMD_MEMWR, CMD_MEMWRI:             kind = ACC_WRITE;
            CMD_CFGRD, CMD_CFGWR:              kind = ACC_CFG;
            default:                           kind = ACC_NONE;
        endcase
    end

    assign in_compat = (addr[ADDR_W-1:REGION_LSB] == REGION_TAG);
    assign win       = addr[REGION_LSB-1:WIN_SHIFT];
    assign below_tom = (addr < tom);

    always_comb begin
        decision = '0;
        unique case (kind)
            ACC_READ:  decision.hit = in_compat ? rd_en[win] : below_tom;
            ACC_WRITE: decision.hit = in_compat ? wr_en[win] : below_tom;
            ACC_CFG: begin
                decision.hit    = cfg_sel;
                decision.to_cfg = 1'b1;
            end
            ACC_NONE:  decision = '0;
        endcase
    end

endmodule

// File: rtl/tcd_burst.sv
`timescale 1ns/1ps
module tcd_burst
    import tcd_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_valid,
    input  logic [ADDR_W-3:0] start_word,
    input  claim_t            decision,
    input  logic              data_done,
    input  logic              burst_end,
    output logic              claim,
    output logic              route_cfg,
    output logic              disconnect
);
    localparam int PAGE_WORD_BITS = PAGE_SHIFT - 2;

    typedef struct packed {
        logic              active;
        logic              cfg;
        logic [ADDR_W-3:0] word;
    } burst_t;

    burst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (addr_valid) begin
            st_d.active = decision.hit;
            st_d.cfg    = decision.hit && decision.to_cfg;
            st_d.word   = start_word;
        end else if (st_q.active) begin
            if (burst_end) begin
                st_d.active = 1'b0;
                st_d.cfg    = 1'b0;
            end else if (data_done) begin
                st_d.word = st_q.word + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign claim      = st_q.active;
    assign route_cfg  = st_q.cfg;
    assign disconnect = st_q.active && !st_q.cfg && (&st_q.word[PAGE_WORD_BITS-1:0]);

endmodule

// File: rtl/tgt_claim_dec.sv
`timescale 1ns/1ps
module tgt_claim_dec
    import tcd_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                WIN_CNT     = 16,
    parameter int                WIN_SHIFT   = 14,
    parameter int                PAGE_SHIFT  = 12,
    parameter logic [ADDR_W-1:0] COMPAT_BASE = 32'h000C_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       addr_valid,
    input  logic [3:0]                 cmd,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       cfg_sel,
    input  logic                       data_done,
    input  logic                       burst_end,
    input  logic                       attr_we,
    input  logic [$clog2(WIN_CNT)-1:0] attr_idx,
    input  logic                       attr_rd,
    input  logic                       attr_wr,
    input  logic                       tom_we,
    input  logic [ADDR_W-1:0]          tom_val,
    output logic                       claim,
    output logic                       route_cfg,
    output logic                       disconnect
);
    logic [WIN_CNT-1:0] rd_en;
    logic [WIN_CNT-1:0] wr_en;
    logic [ADDR_W-1:0]  tom;
    claim_t             decision;

    tcd_regs #(
        .ADDR_W  (ADDR_W),
        .WIN_CNT (WIN_CNT)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .attr_we  (attr_we),
        .attr_idx (attr_idx),
        .attr_rd  (attr_rd),
        .attr_wr  (attr_wr),
        .tom_we   (tom_we),
        .tom_val  (tom_val),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .tom      (tom)
    );

    tcd_decode #(
        .ADDR_W      (ADDR_W),
        .WIN_CNT     (WIN_CNT),
        .WIN_SHIFT   (WIN_SHIFT),
        .COMPAT_BASE (COMPAT_BASE)
    ) u_decode (
        .cmd      (cmd),
        .addr     (addr),
        .cfg_sel  (cfg_sel),
        .rd_en    (rd_en),
        .wr_en    (wr_en),
        .tom      (tom),
        .decision (decision)
    );

    tcd_burst #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_burst (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_valid (addr_valid),
        .start_word (addr[ADDR_W-1:2]),
        .decision   (decision),
        .data_done  (data_done),
        .burst_end  (burst_end),
        .claim      (claim),
        .route_cfg  (route_cfg),
        .disconnect (disconnect)
    );

endmodule

// File: rtl/tcd_checker.sv
`timescale 1ns/1ps
module tcd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       addr_valid,
    input logic [3:0] cmd,
    input logic       cfg_sel,
    input logic       burst_end,
    input logic       claim,
    input logic       route_cfg,
    input logic       disconnect
);
    AST_CLAIM_FROM_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(claim) |-> $past(addr_valid)); // R2

    AST_NO_CLAIM_IO: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && (cmd == 4'h0 || cmd == 4'h1 || cmd == 4'h2 || cmd == 4'h3) |=> !claim); // R6

    AST_CFG_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        addr_valid && (cmd == 4'hA || cmd == 4'hB) && !cfg_sel |=> !claim); // R7

    AST_CFG_NO_DISC: assert property (@(posedge clk) disable iff (!rst_n)
        route_cfg |-> !disconnect); // R7

    AST_ROUTE_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        route_cfg |-> claim); // R7

    AST_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        claim && burst_end && !addr_valid |=> !claim); // R8

    AST_CLAIM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        claim && !burst_end && !addr_valid |=> claim); // R8

    AST_DISC_NEEDS_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        disconnect |-> claim); // R9

endmodule

bind tgt_claim_dec tcd_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_valid (addr_valid),
    .cmd        (cmd),
    .cfg_sel    (cfg_sel),
    .burst_end  (burst_end),
    .claim      (claim),
    .route_cfg  (route_cfg),
    .disconnect (disconnect)
);

// File: tb/sim_tgt_claim_dec.sv
`timescale 1ns/1ps
module sim_tgt_claim_dec;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        addr_valid;
    logic [3:0]  cmd;
    logic [31:0] addr;
    logic        cfg_sel;
    logic        data_done;
    logic        burst_end;
    logic        attr_we;
    logic [3:0]  attr_idx;
    logic        attr_rd;
    logic        attr_wr;
    logic        tom_we;
    logic [31:0] tom_val;
    logic        claim;
    logic        route_cfg;
    logic        disconnect;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    bit          m_rd [16];
    bit          m_wr [16];
    logic [31:0] m_tom;
    bit          m_act;
    bit          m_cfg;
    logic [31:0] m_addr;

    always #10 clk = ~clk;

    tgt_claim_dec u0 (
        .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .cmd(cmd), .addr(addr),
        .cfg_sel(cfg_sel), .data_done(data_done), .burst_end(burst_end),
        .attr_we(attr_we), .attr_idx(attr_idx), .attr_rd(attr_rd), .attr_wr(attr_wr),
        .tom_we(tom_we), .tom_val(tom_val),
        .claim(claim), .route_cfg(route_cfg), .disconnect(disconnect)
    );

    function automatic logic [1:0] model_decide(logic [3:0] c, logic [31:0] a, logic sel);
        bit rd = (c == 4'h6) || (c == 4'hC) || (c == 4'hE);
        bit wr = (c == 4'h7) || (c == 4'hF);
        if (c == 4'hA || c == 4'hB) return {1'b1, sel};
        if (!rd && !wr) return 2'b00;
        if (a >= 32'h000C_0000 && a < 32'h0010_0000) begin
            int w = int'((a - 32'h000C_0000) / 32'd16384);
            return {1'b0, rd ? m_rd[w] : m_wr[w]};
        end
        return {1'b0, a < m_tom};
    endfunction

    task automatic model_step();
        logic [1:0] r = model_decide(cmd, addr, cfg_sel);
        if (addr_valid) begin
            m_act  = r[0];
            m_cfg  = r[0] && r[1];
            m_addr = {addr[31:2], 2'b00};
        end else if (m_act) begin
            if (burst_end) begin
                m_act = 0;
                m_cfg = 0;
            end else if (data_done) begin
                m_addr = m_addr + 32'd4;
            end
        end
        if (attr_we) begin
            m_rd[attr_idx] = attr_rd;
            m_wr[attr_idx] = attr_wr;
        end
        if (tom_we) m_tom = tom_val;
    endtask

    task automatic cmp(string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0b exp=%0b", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_model();
        cmp("claim", claim, m_act);
        cmp("route_cfg", route_cfg, m_cfg);
        cmp("disconnect", disconnect, m_act && !m_cfg && (m_addr[11:0] == 12'hFFC));
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_model();
        addr_valid = 0; data_done = 0; burst_end = 0;
        attr_we = 0; tom_we = 0;
    endtask

    task automatic start(logic [3:0] c, logic [31:0] a, logic sel);
        addr_valid = 1; cmd = c; addr = a; cfg_sel = sel;
        tick();
    endtask

    task automatic stop();
        burst_end = 1;
        tick();
    endtask

    task automatic set_win(int idx, bit rd, bit wr);
        attr_we = 1; attr_idx = 4'(idx); attr_rd = rd; attr_wr = wr;
        tick();
    endtask

    task automatic expect_claim(logic exp_claim, logic exp_cfg);
        cmp("claim(literal)", claim, exp_claim);
        cmp("route_cfg(literal)", route_cfg, exp_cfg);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired during %s", cur_req);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 0; addr_valid = 0; cmd = 4'h0; addr = '0; cfg_sel = 0;
        data_done = 0; burst_end = 0; attr_we = 0; attr_idx = '0;
        attr_rd = 0; attr_wr = 0; tom_we = 0; tom_val = '0;
        m_tom = '0; m_act = 0; m_cfg = 0; m_addr = '0;
        foreach (m_rd[i]) begin m_rd[i] = 0; m_wr[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1;

        cur_req = "R1";
        tick();
        cmp("disconnect(literal)", disconnect, 1'b0);
        expect_claim(0, 0);
        start(4'h6, 32'h0000_1000, 0);
        expect_claim(0, 0);
        stop();

        cur_req = "R2";
        tom_we = 1; tom_val = 32'h0100_0000;
        tick();
        for (int k = 0; k < 5; k++) begin
            logic [3:0] codes [5] = '{4'h6, 4'h7, 4'hC, 4'hE, 4'hF};
            start(codes[k], 32'h0000_1000 + 32'(k * 64), 0);
            expect_claim(1, 0);
            stop();
            expect_claim(0, 0);
        end

        cur_req = "R3";
        start(4'h6, 32'h0100_0000, 0);
        expect_claim(0, 0);
        start(4'h7, 32'h00FF_FFFC, 0);
        expect_claim(1, 0);
        stop();
        start(4'h7, 32'h8000_0000, 0);
        expect_claim(0, 0);

        cur_req = "R4";
        set_win(3, 0, 1);
        set_win(5, 1, 0);
        start(4'h7, 32'h000C_C000, 0);
        expect_claim(1, 0);
        stop();
        start(4'h7, 32'h000D_4010, 0);
        expect_claim(0, 0);
        start(4'hF, 32'h000F_FFFC, 0);
        expect_claim(0, 0);

        cur_req = "R5";
        start(4'h6, 32'h000D_4000, 0);
        expect_claim(1, 0);
        stop();
        start(4'hE, 32'h000C_FFFC, 0);
        expect_claim(0, 0);
        start(4'h6, 32'h000F_0000, 0);
        expect_claim(0, 0);

        cur_req = "R6";
        for (int k = 0; k < 16; k++) begin
            if (k inside {0, 1, 2, 3, 4, 5, 8, 9, 13}) begin
                start(4'(k), 32'h0000_2000, 1);
                expect_claim(0, 0);
            end
        end

        cur_req = "R7";
        start(4'hA, 32'h0000_0FF8, 1);
        expect_claim(1, 1);
        data_done = 1; tick();
        cmp("disconnect(literal)", disconnect, 1'b0);
        stop();
        start(4'hB, 32'h0000_0010, 0);
        expect_claim(0, 0);

        cur_req = "R9";
        start(4'h6, 32'h0000_2FF0, 0);
        cmp("disconnect(literal)", disconnect, 1'b0);
        data_done = 1; tick();
        tick();
        data_done = 1; tick();
        data_done = 1; tick();
        cmp("disconnect(literal)", disconnect, 1'b1);
        data_done = 1; tick();
        cmp("disconnect(literal)", disconnect, 1'b0);

        cur_req = "R8";
        burst_end = 1; addr_valid = 1; cmd = 4'h7; addr = 32'h0000_5FFC; cfg_sel = 0;
        tick();
        expect_claim(1, 0);
        cmp("disconnect(literal)", disconnect, 1'b1);
        repeat (3) tick();
        expect_claim(1, 0);
        burst_end = 1; data_done = 1; tick();
        expect_claim(0, 0);

        cur_req = "R10";
        attr_we = 1; attr_idx = 4'd7; attr_rd = 1; attr_wr = 1;
        start(4'h7, 32'h000D_C000, 0);
        expect_claim(0, 0);
        start(4'h7, 32'h000D_C000, 0);
        expect_claim(1, 0);
        stop();
        tom_we = 1; tom_val = 32'h0000_4000;
        start(4'h6, 32'h0000_8000, 0);
        expect_claim(1, 0);
        stop();
        start(4'h6, 32'h0000_8000, 0);
        expect_claim(0, 0);
        start(4'h6, 32'h000D_C000, 0);
        expect_claim(1, 0);
        stop();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule